// File: doc/BRIEF.md
# Status Register and Write Guard

This block holds the protection state of a small serial non-volatile memory: a write-enable latch, two block-protect bits and the ready/busy flag. It receives one-cycle strobes from the instruction decoder (enable, disable, status program request), the level of the hardware write-protect pin, the target byte address of a pending data write and the busy and completion signals of the program sequencer. From these it builds the byte returned by a status read and tells the sequencer whether a data write or a status program may start.

The block-protect bits model non-volatile cells. An accepted status program request stores the new value in a pending register, shown on `bp_next_o`. The visible bits take that value only when the sequencer reports that a status program cycle has finished. The protected range is always the upper part of the array, cut at the top two address bits: the top quarter, the top half, or the whole array.

Top module: `sr_guard`

## Requirements
- R1: After reset the write-enable latch is clear, the block-protect bits hold `BP_RESET` (default 00), and `status_o` reads 0x00 while not busy.
- R2: While `busy_i` is low, `status_o` is {4'b0000, BP1, BP0, WEL, 1'b0}: bit 3 BP1, bit 2 BP0, bit 1 the write-enable latch, bit 0 ready/busy (0 = ready).
- R3: While `busy_i` is high, `status_o` reads 0xFF: bit 0 is 1 for busy and every other bit reads 1.
- R4: `wren_i` sets the latch at the next clock edge only when `wp_n_i` is high and `busy_i` is low. Otherwise it has no effect.
- R5: `wrdi_i` clears the latch when not busy, whatever the level of `wp_n_i`. A low `wp_n_i` clears the latch at every clock edge. A clear wins over a set in the same cycle.
- R6: A `prog_done_i` pulse clears the latch, for both a data program and a status program.
- R7: Protected addresses by {BP1,BP0}: 00 none; 01 top two address bits 11 (0x180-0x1FF); 10 top address bit 1 (0x100-0x1FF); 11 the whole array. With level 01, 0x17F is writable and 0x180 is not. With level 10, 0x0FF is writable and 0x100 is not.
- R8: `write_ok_o` is 1 only when `wp_n_i` is high, the latch is set, `busy_i` is low and `addr_i` is outside the protected range.
- R9: `wrsr_ok_o` is 1 only when `wp_n_i` is high, the latch is set and `busy_i` is low. A `wrsr_req_i` pulse while it is 1 loads bits 3 and 2 of `wrsr_data_i` into `bp_next_o`. All other data bits are ignored.
- R10: The visible block-protect bits change only on `prog_done_i` with `prog_is_sr_i` = 1. A rejected status program request leaves both `bp_next_o` and the visible bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Write-protect pin level, high permits programming |
| wren_i | input | 1 | Decoded enable-write strobe |
| wrdi_i | input | 1 | Decoded disable-write strobe |
| wrsr_req_i | input | 1 | Status program request strobe (select released after data) |
| wrsr_data_i | input | 8 | Data byte of the status program request |
| addr_i | input | ADDR_W | Target byte address of the pending data write |
| busy_i | input | 1 | Program cycle in progress, from the sequencer |
| prog_done_i | input | 1 | One-cycle pulse at the end of a program cycle |
| prog_is_sr_i | input | 1 | Qualifies `prog_done_i`: 1 = status program, 0 = data program |
| status_o | output | 8 | Byte returned by a status read |
| write_ok_o | output | 1 | Data write to `addr_i` is permitted |
| wrsr_ok_o | output | 1 | Status program request would be accepted |
| bp_next_o | output | 2 | Pending block-protect value for the sequencer to program |

## Verification
The assertions check on every cycle that a busy status reads all ones and that an idle status has zeros in its upper nibble and in bit 0. They also check that a low protect pin or a program completion leaves the latch clear, that neither permit is given without the pin, the latch and an idle sequencer, that no write is permitted at full protection, and that the visible protect bits hold outside a status program completion. Only the bench's scenarios can show the exact boundary addresses at each protection level, that set-before-clear ordering is right, and that a rejected status request leaves the stored level unchanged through a later completion. The same holds for a request that carries junk in its don't-care bits.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

  localparam int SR_W = 8;
  localparam int BP_W = 2;

  // Bit positions of the status byte, decoded by the serial read path.
  localparam int SR_RDY = 0;
  localparam int SR_WEL = 1;
  localparam int SR_BP0 = 2;
  localparam int SR_BP1 = 3;

  typedef enum logic [1:0] {
    LVL_OPEN    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } prot_lvl_e;

  // Protection depends only on the two most significant address bits.
  function automatic logic quad_blocked(input logic [1:0] lvl, input logic [1:0] top2);
    logic hit;
    unique case (lvl)
      LVL_OPEN:    hit = 1'b0;
      LVL_QUARTER: hit = (top2 == 2'b11);
      LVL_HALF:    hit = top2[1];
      default:     hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/wel_latch.sv
module wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);

  logic wel_q;
  logic wel_d;
  logic wel_en;

  // Clear has priority over set.
  always_comb begin
    wel_en = set_i | clr_i;
    wel_d  = ~clr_i & set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
    end else if (wel_en) begin
      wel_q <= wel_d;
    end
  end

  assign wel_o = wel_q;

endmodule

// File: rtl/bp_store.sv
module bp_store
  import sr_guard_pkg::*;
#(
  parameter logic [BP_W-1:0] BP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [BP_W-1:0] load_val_i,
  input  logic            commit_i,
  output logic [BP_W-1:0] pend_o,
  output logic [BP_W-1:0] bp_o
);

  logic [BP_W-1:0] pend_q;
  logic [BP_W-1:0] bp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= BP_RESET;
    end else if (load_i) begin
      pend_q <= load_val_i;
    end
  end

  // Visible cells move only at the end of a status program cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q <= BP_RESET;
    end else if (commit_i) begin
      bp_q <= pend_q;
    end
  end

  assign pend_o = pend_q;
  assign bp_o   = bp_q;

endmodule

// File: rtl/prot_window.sv
module prot_window
  import sr_guard_pkg::*;
(
  input  logic [BP_W-1:0] lvl_i,
  input  logic [1:0]      top2_i,
  output logic            blocked_o
);

  always_comb begin
    blocked_o = quad_blocked(lvl_i, top2_i);
  end

endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int               ADDR_W   = 9,
  parameter logic [BP_W-1:0]  BP_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_req_i,
  input  logic [SR_W-1:0]   wrsr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic              prog_done_i,
  input  logic              prog_is_sr_i,
  output logic [SR_W-1:0]   status_o,
  output logic              write_ok_o,
  output logic              wrsr_ok_o,
  output logic [BP_W-1:0]   bp_next_o
);

  localparam int TOP_LSB = ADDR_W - 2;

  logic            wel_q;
  logic            wel_set;
  logic            wel_clr;
  logic            bp_load;
  logic            bp_commit;
  logic [BP_W-1:0] bp_q;
  logic [BP_W-1:0] bp_pend;
  logic [BP_W-1:0] bp_in;
  logic            addr_blocked;
  logic            unused_sr_bits;

  assign unused_sr_bits = ^{wrsr_data_i[SR_W-1:SR_BP1+1], wrsr_data_i[SR_WEL:SR_RDY]};

  // Latch control: only the status read is honoured while busy.
  always_comb begin
    wel_set = wren_i & wp_n_i & ~busy_i;
    wel_clr = (wrdi_i & ~busy_i) | ~wp_n_i | prog_done_i;
  end

  wel_latch u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wel_set),
    .clr_i (wel_clr),
    .wel_o (wel_q)
  );

  always_comb begin
    wrsr_ok_o = wp_n_i & wel_q & ~busy_i;
    bp_load   = wrsr_req_i & wrsr_ok_o;
    bp_in     = {wrsr_data_i[SR_BP1], wrsr_data_i[SR_BP0]};
    bp_commit = prog_done_i & prog_is_sr_i;
  end

  bp_store #(
    .BP_RESET (BP_RESET)
  ) u_bp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (bp_load),
    .load_val_i (bp_in),
    .commit_i   (bp_commit),
    .pend_o     (bp_pend),
    .bp_o       (bp_q)
  );

  prot_window u_win (
    .lvl_i     (bp_q),
    .top2_i    (addr_i[ADDR_W-1:TOP_LSB]),
    .blocked_o (addr_blocked)
  );

  always_comb begin
    write_ok_o = wp_n_i & wel_q & ~busy_i & ~addr_blocked;
    bp_next_o  = bp_pend;
    if (busy_i) begin
      status_o = '1;
    end else begin
      status_o         = '0;
      status_o[SR_BP1] = bp_q[1];
      status_o[SR_BP0] = bp_q[0];
      status_o[SR_WEL] = wel_q;
      status_o[SR_RDY] = 1'b0;
    end
  end

endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n_i,
  input logic       busy_i,
  input logic       prog_done_i,
  input logic       prog_is_sr_i,
  input logic [7:0] status_o,
  input logic       write_ok_o,
  input logic       wrsr_ok_o,
  input logic [1:0] bp_q
);

  p_busy_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (status_o == 8'hFF));

  p_idle_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (status_o[7:4] == 4'h0 && !status_o[0]));

  p_wp_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n_i |=> (busy_i || !status_o[1]));

  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done_i |=> (busy_i || !status_o[1]));

  p_write_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    write_ok_o |-> (wp_n_i && !busy_i && status_o[1]));

  p_wrsr_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_ok_o |-> (wp_n_i && !busy_i && status_o[1]));

  p_full_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_q == 2'b11) |-> !write_ok_o);

  p_bp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_done_i && prog_is_sr_i) |=> $stable(bp_q));

endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wp_n_i       (wp_n_i),
  .busy_i       (busy_i),
  .prog_done_i  (prog_done_i),
  .prog_is_sr_i (prog_is_sr_i),
  .status_o     (status_o),
  .write_ok_o   (write_ok_o),
  .wrsr_ok_o    (wrsr_ok_o),
  .bp_q         (bp_q)
);

// File: tb/tb_sr_guard.sv
module tb_sr_guard;

  logic       clk;
  logic       rst_n;
  logic       wp_n, wren, wrdi, wrsr_req, busy, done, is_sr;
  logic [7:0] wrsr_data;
  logic [8:0] addr;
  logic [7:0] status;
  logic       write_ok, wrsr_ok;
  logic [1:0] bp_next;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  sr_guard dut (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .wren_i(wren), .wrdi_i(wrdi),
    .wrsr_req_i(wrsr_req), .wrsr_data_i(wrsr_data), .addr_i(addr),
    .busy_i(busy), .prog_done_i(done), .prog_is_sr_i(is_sr),
    .status_o(status), .write_ok_o(write_ok), .wrsr_ok_o(wrsr_ok),
    .bp_next_o(bp_next)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_wren();
    wren = 1'b1; step(); wren = 1'b0; #1;
  endtask

  task automatic pulse_wrdi();
    wrdi = 1'b1; step(); wrdi = 1'b0; #1;
  endtask

  task automatic run_prog(input logic sr);
    busy = 1'b1; step();
    check("R3 busy status", status, 8'hFF);
    done = 1'b1; is_sr = sr; step();
    done = 1'b0; is_sr = 1'b0; busy = 1'b0; #1;
  endtask

  function automatic bit blocked(input int lvl, input int a);
    case (lvl)
      0: return 1'b0;
      1: return a >= 'h180;
      2: return a >= 'h100;
      default: return 1'b1;
    endcase
  endfunction

  task automatic set_level(input int lvl);
    wp_n = 1'b1;
    pulse_wren();
    wrsr_data = {4'hA, lvl[1:0], 2'b11};
    wrsr_req = 1'b1; #1;
    check("R9 wrsr accepted", wrsr_ok, 1);
    step();
    wrsr_req = 1'b0; #1;
    check("R9 pending bits 3:2", bp_next, lvl);
    run_prog(1'b1);
    check("R10 committed level", status, lvl << 2);
  endtask

  task automatic t_reset();
    check("R1 reset status", status, 8'h00);
    check("R1 reset bp_next", bp_next, 0);
    check("R1 reset write_ok", write_ok, 0);
  endtask

  task automatic t_wren_wp();
    wp_n = 1'b0; pulse_wren(); wp_n = 1'b1; #1;
    check("R4 wren ignored with wp low", status, 8'h00);
    pulse_wren();
    check("R2 R4 wel bit set", status, 8'h02);
    wp_n = 1'b0; step(); wp_n = 1'b1; #1;
    check("R5 wp low clears", status, 8'h00);
    pulse_wren(); wp_n = 1'b0; #1; pulse_wrdi(); wp_n = 1'b1; #1;
    check("R5 wrdi with wp low", status, 8'h00);
    pulse_wren(); pulse_wrdi();
    check("R5 wrdi clears", status, 8'h00);
    wren = 1'b1; wrdi = 1'b1; step(); wren = 1'b0; wrdi = 1'b0; #1;
    check("R5 clear wins", status, 8'h00);
  endtask

  task automatic t_busy();
    busy = 1'b1; wren = 1'b1; step(); wren = 1'b0;
    check("R3 status while busy", status, 8'hFF);
    busy = 1'b0; #1;
    check("R4 wren ignored while busy", status, 8'h00);
    pulse_wren();
    busy = 1'b1; addr = 9'h000; #1;
    check("R8 no write while busy", write_ok, 0);
    check("R9 no wrsr while busy", wrsr_ok, 0);
    busy = 1'b0; #1;
    check("R8 write allowed idle", write_ok, 1);
    run_prog(1'b0);
    check("R6 data program clears wel", status, 8'h00);
  endtask

  task automatic t_wrsr_reject();
    wp_n = 1'b1; wrsr_data = 8'h0C; wrsr_req = 1'b1; #1;
    check("R9 wrsr refused without wel", wrsr_ok, 0);
    step(); wrsr_req = 1'b0; #1;
    check("R10 bp_next unchanged", bp_next, 0);
    run_prog(1'b1);
    check("R10 rejected leaves bp", status, 8'h00);
    pulse_wren(); wp_n = 1'b0; wrsr_req = 1'b1; #1;
    check("R9 wrsr refused wp low", wrsr_ok, 0);
    step(); wrsr_req = 1'b0; wp_n = 1'b1; #1;
    check("R10 bp_next unchanged wp low", bp_next, 0);
  endtask

  task automatic t_levels();
    int probes[6] = '{'h000, 'h0FF, 'h100, 'h17F, 'h180, 'h1FF};
    for (int lvl = 1; lvl <= 3; lvl++) begin
      set_level(lvl);
      check("R6 status program clears wel", status[1], 0);
      pulse_wren();
      for (int i = 0; i < 6; i++) begin
        addr = probes[i][8:0]; #1;
        check($sformatf("R7 lvl%0d addr %0h", lvl, probes[i]), write_ok, !blocked(lvl, probes[i]));
      end
      wp_n = 1'b0; step(); wp_n = 1'b1; addr = 9'h000; #1;
      check("R8 write refused after wp low", write_ok, 0);
    end
    set_level(0);
    pulse_wren(); addr = 9'h1FF; #1;
    check("R7 level 0 top open", write_ok, 1);
    pulse_wrdi();
  endtask

  initial begin
    rst_n = 1'b0; wp_n = 1'b1; wren = 0; wrdi = 0; wrsr_req = 0;
    wrsr_data = 8'h00; addr = '0; busy = 0; done = 0; is_sr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_wren_wp();
    t_busy();
    t_wrsr_reject();
    t_levels();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule